// File: doc/BRIEF.md
# CD-ROM Sector Framer with Descrambler

This block sits between the serial output of a CD player front end and a sector buffer. It deserializes the incoming bit stream, which arrives with a bit clock, a data line, a 44.1 kHz left/right strobe and a per-byte error flag. It then locks onto the 12-byte sector sync mark and emits every byte of each 2352-byte raw sector in arrival order. Each byte comes out with a write strobe, its index within the sector, a sector-start flag and the error flag that arrived with it. The sync bytes themselves are emitted too. Bytes from index 12 onward are descrambled before they leave the block.

Framing has two independent sources, and each can be switched on or off. The first is a pattern matcher that recognises the sync mark anywhere in the stream. The second is a flywheel counter that produces the sector boundary on its own after 2352 bytes. With both enabled, the framer tolerates a damaged sync mark. It still jumps to a sync mark that turns up early. The serial word layout is chosen from three formats by a two-bit select.

Top module: `cdsec_sector_sync`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the write strobe and sector-start flag are low and the byte, index and error-flag outputs are zero.
- R2: Format 0: each 16-bit word (bit counter restarts on every strobe change, sampled on bit clock rising edges) is sent MSB first. The second 8 serial bits form the earlier sector byte.
- R3: Format 1: each word is sent LSB first. The first 8 serial bits form the earlier sector byte.
- R4: Format 2: each word is sent MSB first, and the first 8 serial bits form the earlier sector byte. Format 3 behaves as format 0.
- R5: With detection enabled, the sequence 0x00, ten times 0xFF, 0x00 marks a sector. Its first byte is emitted with index 0 and the start flag. No byte is emitted before the first sector start.
- R6: Within a sector, each emitted byte carries the previous index plus one. Every byte of the sector is emitted in arrival order, up to index 2351.
- R7: With interpolation enabled, if no sync mark is detected where the byte after index 2351 would fall, that byte is emitted with index 0 and the start flag.
- R8: With detection enabled, a sync mark found at an unexpected position restarts the sector at index 0 with the start flag.
- R9: With detection disabled, a sync mark in the data has no effect on the indices or the start flag.
- R10: With interpolation disabled and no sync mark at the expected boundary, output stops until the next detected sync mark. That mark is then emitted with index 0 and the start flag.
- R11: Bytes 0..11 pass unchanged. From byte 12 on, each byte is XORed with 8 successive low bits of a 15-bit LFSR (x^15 + x + 1), taken LSB first. The LFSR is seeded to 0x0001 at byte 12, and each step shifts right with bit0 XOR bit1 entering bit 14.
- R12: The error flag level during the eighth serial bit of a byte is emitted alongside that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bck_i | input | 1 | Serial bit clock, sampled in the clk domain |
| ser_data_i | input | 1 | Serial data line |
| ser_lrck_i | input | 1 | Left/right word strobe |
| c2_flag_i | input | 1 | Per-byte error flag from the player |
| fmt_sel_i | input | 2 | Serial format select |
| det_en_i | input | 1 | Enable for the sync mark matcher |
| interp_en_i | input | 1 | Enable for the flywheel boundary |
| sec_byte_o | output | 8 | Framed, descrambled byte |
| sec_wr_o | output | 1 | Byte write strobe |
| sec_idx_o | output | 12 | Byte index within the sector |
| sec_start_o | output | 1 | First byte of a sector |
| sec_c2_o | output | 1 | Error flag of the emitted byte |

## Verification
The hardest case to reach from the ports is the loss and recovery of framing. Interpolation must be off at the exact moment a full sector has elapsed with no sync mark present. To get there, the stimulus streams a complete sector, changes the enables at a word boundary just before the next sector, and sends a damaged mark. It then checks that nothing leaves the block until a genuine mark arrives. A related case is a fake sync mark inside the payload while detection is off. The bench must show that this mark leaves the indices untouched, while the scoreboard still expects every byte in order.

// File: rtl/cdsec_pkg.sv
package cdsec_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int SYNC_LEN = 12;
    localparam int LFSR_W   = 15;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 15'h0001;

    typedef enum logic [1:0] {
        FMT_MSB_LATE  = 2'd0,
        FMT_LSB       = 2'd1,
        FMT_MSB_EARLY = 2'd2,
        FMT_ALIAS     = 2'd3
    } ser_fmt_e;

    typedef logic [SYNC_LEN-1:0][BYTE_W-1:0] sync_win_t;

    // Sync mark: zero byte at both ends, 0xFF in between.
    function automatic sync_win_t sync_pattern();
        sync_win_t p;
        for (int i = 0; i < SYNC_LEN; i++) begin
            p[i] = (i == 0 || i == SYNC_LEN - 1) ? 8'h00 : 8'hFF;
        end
        return p;
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step8(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] t;
        t = s;
        for (int b = 0; b < BYTE_W; b++) begin
            t = {t[0] ^ t[1], t[LFSR_W-1:1]};
        end
        return t;
    endfunction

    function automatic logic [BYTE_W-1:0] lfsr_key(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] t;
        logic [BYTE_W-1:0] k;
        t = s;
        k = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            k[b] = t[0];
            t    = {t[0] ^ t[1], t[LFSR_W-1:1]};
        end
        return k;
    endfunction

endpackage

// File: rtl/cdsec_deser.sv
module cdsec_deser
    import cdsec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bck_i,
    input  logic              sd_i,
    input  logic              lr_i,
    input  logic              c2_i,
    input  logic [1:0]        fmt_i,
    output logic              word_vld_o,
    output logic [BYTE_W-1:0] early_byte_o,
    output logic [BYTE_W-1:0] late_byte_o,
    output logic              early_c2_o,
    output logic              late_c2_o
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] MID_BIT  = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              bck;
        logic              bck_prev;
        logic              sd;
        logic              lr;
        logic              c2;
        logic              lr_last;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic              c2_mid;
        logic              vld;
        logic [BYTE_W-1:0] b_early;
        logic [BYTE_W-1:0] b_late;
        logic              f_early;
        logic              f_late;
    } deser_st_t;

    localparam deser_st_t RST_ST = '{cnt: LAST_BIT, default: '0};

    deser_st_t s_d, s_q;

    always_comb begin
        logic              rise;
        logic              lsb;
        logic              first_in_word;
        logic [CNT_W-1:0]  cnt_n;
        logic [WORD_W-1:0] sh_n;
        logic [BYTE_W-1:0] ser_first;
        logic [BYTE_W-1:0] ser_second;

        s_d          = s_q;
        s_d.bck      = bck_i;
        s_d.bck_prev = s_q.bck;
        s_d.sd       = sd_i;
        s_d.lr       = lr_i;
        s_d.c2       = c2_i;
        s_d.vld      = 1'b0;

        rise          = s_q.bck & ~s_q.bck_prev;
        lsb           = (fmt_i == FMT_LSB);
        first_in_word = (fmt_i == FMT_LSB) || (fmt_i == FMT_MSB_EARLY);
        cnt_n         = (s_q.lr != s_q.lr_last) ? '0 : s_q.cnt + 1'b1;
        sh_n          = lsb ? {s_q.sd, s_q.sh[WORD_W-1:1]} : {s_q.sh[WORD_W-2:0], s_q.sd};
        ser_first     = lsb ? sh_n[BYTE_W-1:0] : sh_n[WORD_W-1:BYTE_W];
        ser_second    = lsb ? sh_n[WORD_W-1:BYTE_W] : sh_n[BYTE_W-1:0];

        if (rise) begin
            s_d.cnt     = cnt_n;
            s_d.lr_last = s_q.lr;
            s_d.sh      = sh_n;
            if (cnt_n == MID_BIT) begin
                s_d.c2_mid = s_q.c2;
            end
            if (cnt_n == LAST_BIT) begin
                s_d.vld = 1'b1;
                if (first_in_word) begin
                    s_d.b_early = ser_first;
                    s_d.f_early = s_q.c2_mid;
                    s_d.b_late  = ser_second;
                    s_d.f_late  = s_q.c2;
                end else begin
                    s_d.b_early = ser_second;
                    s_d.f_early = s_q.c2;
                    s_d.b_late  = ser_first;
                    s_d.f_late  = s_q.c2_mid;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= RST_ST;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_vld_o   = s_q.vld;
    assign early_byte_o = s_q.b_early;
    assign late_byte_o  = s_q.b_late;
    assign early_c2_o   = s_q.f_early;
    assign late_c2_o    = s_q.f_late;

endmodule

// File: rtl/cdsec_framer.sv
module cdsec_framer
    import cdsec_pkg::*;
#(
    parameter int SECT_BYTES = 2352,
    parameter int IDX_W      = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld_i,
    input  logic [BYTE_W-1:0] early_byte_i,
    input  logic [BYTE_W-1:0] late_byte_i,
    input  logic              early_c2_i,
    input  logic              late_c2_i,
    input  logic              det_en_i,
    input  logic              interp_en_i,
    output logic              out_vld_o,
    output logic [BYTE_W-1:0] out_byte_o,
    output logic              out_c2_o,
    output logic [IDX_W-1:0]  out_idx_o,
    output logic              out_start_o
);

    localparam int FILL_W = $clog2(SYNC_LEN + 1);
    localparam logic [FILL_W-1:0] FILL_MAX  = FILL_W'(SYNC_LEN);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(SYNC_LEN - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(SECT_BYTES - 1);
    localparam sync_win_t         PATTERN   = sync_pattern();

    typedef struct packed {
        sync_win_t           win;
        logic [SYNC_LEN-1:0] win_c2;
        logic [FILL_W-1:0]   fill;
        logic                hold_vld;
        logic [BYTE_W-1:0]   hold_byte;
        logic                hold_c2;
        logic [IDX_W-1:0]    idx;
        logic                locked;
        logic                o_vld;
        logic [BYTE_W-1:0]   o_byte;
        logic                o_c2;
        logic [IDX_W-1:0]    o_idx;
        logic                o_start;
    } frm_st_t;

    frm_st_t s_d, s_q;

    always_comb begin
        logic                step;
        logic [BYTE_W-1:0]   nb;
        logic                nc;
        sync_win_t           win_n;
        logic [SYNC_LEN-1:0] c2_n;
        logic                full;
        logic                match;

        s_d         = s_q;
        s_d.o_vld   = 1'b0;
        s_d.o_start = 1'b0;
        step        = 1'b0;
        nb          = '0;
        nc          = 1'b0;

        if (word_vld_i) begin
            step          = 1'b1;
            nb            = early_byte_i;
            nc            = early_c2_i;
            s_d.hold_vld  = 1'b1;
            s_d.hold_byte = late_byte_i;
            s_d.hold_c2   = late_c2_i;
        end else if (s_q.hold_vld) begin
            step         = 1'b1;
            nb           = s_q.hold_byte;
            nc           = s_q.hold_c2;
            s_d.hold_vld = 1'b0;
        end

        win_n = {s_q.win[SYNC_LEN-2:0], nb};
        c2_n  = {s_q.win_c2[SYNC_LEN-2:0], nc};
        full  = (s_q.fill >= FILL_FULL);
        match = det_en_i && full && (win_n == PATTERN);

        if (step) begin
            s_d.win    = win_n;
            s_d.win_c2 = c2_n;
            if (s_q.fill != FILL_MAX) begin
                s_d.fill = s_q.fill + 1'b1;
            end
            s_d.o_byte = win_n[SYNC_LEN-1];
            s_d.o_c2   = c2_n[SYNC_LEN-1];
            if (match) begin
                s_d.o_vld   = 1'b1;
                s_d.o_start = 1'b1;
                s_d.o_idx   = '0;
                s_d.idx     = IDX_W'(1);
                s_d.locked  = 1'b1;
            end else if (s_q.locked) begin
                if (s_q.idx == '0) begin
                    if (interp_en_i) begin
                        s_d.o_vld   = 1'b1;
                        s_d.o_start = 1'b1;
                        s_d.o_idx   = '0;
                        s_d.idx     = IDX_W'(1);
                    end else begin
                        s_d.locked = 1'b0;
                    end
                end else begin
                    s_d.o_vld = 1'b1;
                    s_d.o_idx = s_q.idx;
                    s_d.idx   = (s_q.idx == IDX_LAST) ? '0 : s_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_vld_o   = s_q.o_vld;
    assign out_byte_o  = s_q.o_byte;
    assign out_c2_o    = s_q.o_c2;
    assign out_idx_o   = s_q.o_idx;
    assign out_start_o = s_q.o_start;

endmodule

// File: rtl/cdsec_descr.sv
module cdsec_descr
    import cdsec_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld_i,
    input  logic [BYTE_W-1:0] in_byte_i,
    input  logic              in_c2_i,
    input  logic [IDX_W-1:0]  in_idx_i,
    input  logic              in_start_i,
    output logic              out_vld_o,
    output logic [BYTE_W-1:0] out_byte_o,
    output logic              out_c2_o,
    output logic [IDX_W-1:0]  out_idx_o,
    output logic              out_start_o
);

    localparam logic [IDX_W-1:0] KEY_FIRST = IDX_W'(SYNC_LEN);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic              vld;
        logic [BYTE_W-1:0] byte_v;
        logic              c2;
        logic [IDX_W-1:0]  idx;
        logic              start;
    } dsc_st_t;

    dsc_st_t s_d, s_q;

    always_comb begin
        logic [LFSR_W-1:0] cur;

        s_d       = s_q;
        s_d.vld   = 1'b0;
        s_d.start = 1'b0;
        cur       = (in_idx_i == KEY_FIRST) ? LFSR_SEED : s_q.lfsr;

        if (in_vld_i) begin
            s_d.vld    = 1'b1;
            s_d.start  = in_start_i;
            s_d.c2     = in_c2_i;
            s_d.idx    = in_idx_i;
            s_d.byte_v = in_byte_i;
            if (in_idx_i >= KEY_FIRST) begin
                s_d.byte_v = in_byte_i ^ lfsr_key(cur);
                s_d.lfsr   = lfsr_step8(cur);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_vld_o   = s_q.vld;
    assign out_byte_o  = s_q.byte_v;
    assign out_c2_o    = s_q.c2;
    assign out_idx_o   = s_q.idx;
    assign out_start_o = s_q.start;

endmodule

// File: rtl/cdsec_sector_sync.sv
module cdsec_sector_sync
    import cdsec_pkg::*;
#(
    parameter  int SECT_BYTES = 2352,
    localparam int IDX_W      = $clog2(SECT_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_bck_i,
    input  logic             ser_data_i,
    input  logic             ser_lrck_i,
    input  logic             c2_flag_i,
    input  logic [1:0]       fmt_sel_i,
    input  logic             det_en_i,
    input  logic             interp_en_i,
    output logic [7:0]       sec_byte_o,
    output logic             sec_wr_o,
    output logic [IDX_W-1:0] sec_idx_o,
    output logic             sec_start_o,
    output logic             sec_c2_o
);

    logic              w_vld;
    logic [BYTE_W-1:0] w_early, w_late;
    logic              w_c2_early, w_c2_late;

    logic              f_vld, f_c2, f_start;
    logic [BYTE_W-1:0] f_byte;
    logic [IDX_W-1:0]  f_idx;

    cdsec_deser u_deser (
        .clk          (clk),
        .rst          (rst),
        .bck_i        (ser_bck_i),
        .sd_i         (ser_data_i),
        .lr_i         (ser_lrck_i),
        .c2_i         (c2_flag_i),
        .fmt_i        (fmt_sel_i),
        .word_vld_o   (w_vld),
        .early_byte_o (w_early),
        .late_byte_o  (w_late),
        .early_c2_o   (w_c2_early),
        .late_c2_o    (w_c2_late)
    );

    cdsec_framer #(
        .SECT_BYTES (SECT_BYTES),
        .IDX_W      (IDX_W)
    ) u_framer (
        .clk          (clk),
        .rst          (rst),
        .word_vld_i   (w_vld),
        .early_byte_i (w_early),
        .late_byte_i  (w_late),
        .early_c2_i   (w_c2_early),
        .late_c2_i    (w_c2_late),
        .det_en_i     (det_en_i),
        .interp_en_i  (interp_en_i),
        .out_vld_o    (f_vld),
        .out_byte_o   (f_byte),
        .out_c2_o     (f_c2),
        .out_idx_o    (f_idx),
        .out_start_o  (f_start)
    );

    cdsec_descr #(
        .IDX_W (IDX_W)
    ) u_descr (
        .clk         (clk),
        .rst         (rst),
        .in_vld_i    (f_vld),
        .in_byte_i   (f_byte),
        .in_c2_i     (f_c2),
        .in_idx_i    (f_idx),
        .in_start_i  (f_start),
        .out_vld_o   (sec_wr_o),
        .out_byte_o  (sec_byte_o),
        .out_c2_o    (sec_c2_o),
        .out_idx_o   (sec_idx_o),
        .out_start_o (sec_start_o)
    );

endmodule

// File: rtl/cdsec_checker.sv
module cdsec_checker #(
    parameter int SECT_BYTES = 2352,
    parameter int IDX_W      = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       sec_byte_o,
    input logic             sec_wr_o,
    input logic [IDX_W-1:0] sec_idx_o,
    input logic             sec_start_o,
    input logic             sec_c2_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SECT_BYTES - 1);
    localparam logic [IDX_W:0]   IDX_LIM  = (IDX_W+1)'(SECT_BYTES);

    logic             seen_q;
    logic [IDX_W-1:0] last_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q     <= 1'b0;
            last_idx_q <= '0;
        end else if (sec_wr_o) begin
            seen_q     <= 1'b1;
            last_idx_q <= sec_idx_o;
        end
    end

    // R1: reset leaves the output idle on the following edge
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sec_wr_o && !sec_start_o && sec_byte_o == 8'h00 && !sec_c2_o));

    // R5: a sector start is always a written byte at index 0
    a_r5_start_at_zero: assert property (@(posedge clk) disable iff (rst)
        sec_start_o |-> (sec_wr_o && sec_idx_o == '0));

    // R6: index stays inside the sector
    a_r6_idx_range: assert property (@(posedge clk) disable iff (rst)
        sec_wr_o |-> ({1'b0, sec_idx_o} < IDX_LIM));

    // R6: without a start, the index follows the previous one
    a_r6_idx_step: assert property (@(posedge clk) disable iff (rst)
        (sec_wr_o && !sec_start_o) |-> (seen_q && sec_idx_o == last_idx_q + 1'b1));

    // R7: the byte after the last index opens a new sector
    a_r7_wrap_starts: assert property (@(posedge clk) disable iff (rst)
        (sec_wr_o && seen_q && last_idx_q == IDX_LAST) |-> sec_start_o);

endmodule

bind cdsec_sector_sync cdsec_checker #(
    .SECT_BYTES (SECT_BYTES),
    .IDX_W      (IDX_W)
) u_cdsec_checker (
    .clk         (clk),
    .rst         (rst),
    .sec_byte_o  (sec_byte_o),
    .sec_wr_o    (sec_wr_o),
    .sec_idx_o   (sec_idx_o),
    .sec_start_o (sec_start_o),
    .sec_c2_o    (sec_c2_o)
);

// File: tb/cdsec_sector_sync_bench.sv
module cdsec_sector_sync_bench;

    localparam int NSEC = 2352;

    logic        clk = 1'b0;
    logic        rst;
    logic        bck, sd, lr, c2;
    logic [1:0]  fmt;
    logic        det_en, interp_en;
    logic [7:0]  sec_byte;
    logic        sec_wr;
    logic [11:0] sec_idx;
    logic        sec_start;
    logic        sec_c2;

    always #5 clk = ~clk;

    cdsec_sector_sync u_cdsec_sector_sync (
        .clk         (clk),
        .rst         (rst),
        .ser_bck_i   (bck),
        .ser_data_i  (sd),
        .ser_lrck_i  (lr),
        .c2_flag_i   (c2),
        .fmt_sel_i   (fmt),
        .det_en_i    (det_en),
        .interp_en_i (interp_en),
        .sec_byte_o  (sec_byte),
        .sec_wr_o    (sec_wr),
        .sec_idx_o   (sec_idx),
        .sec_start_o (sec_start),
        .sec_c2_o    (sec_c2)
    );

    typedef struct {
        logic [7:0]  b;
        logic [11:0] idx;
        logic        st;
        logic        c2;
        int          tf;
        int          td;
    } exp_t;

    exp_t        expq[$];
    int          vectors = 0;
    int          miscompares = 0;
    logic [7:0]  key [NSEC];
    logic        lr_cur = 1'b0;
    logic        have_pend = 1'b0;
    logic [7:0]  pend_b;
    logic        pend_c;

    function automatic string req_name(int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11"; 12: return "R12";
            default: return "R?";
        endcase
    endfunction

    function automatic int fmt_tag();
        case (fmt)
            2'd0: return 2;
            2'd1: return 3;
            default: return 4;
        endcase
    endfunction

    // R11 key stream from the stated polynomial and seed
    initial begin
        logic [14:0] s;
        s = 15'h0001;
        for (int i = 0; i < NSEC; i++) begin
            key[i] = 8'h00;
            if (i >= 12) begin
                for (int b = 0; b < 8; b++) begin
                    key[i][b] = s[0];
                    s = {s[0] ^ s[1], s[14:1]};
                end
            end
        end
    end

    task automatic put_bit(input logic bv, input logic cv);
        @(negedge clk);
        bck = 1'b0; sd = bv; lr = lr_cur; c2 = cv;
        @(negedge clk);
        bck = 1'b1;
    endtask

    task automatic send_byte_ser(input logic [7:0] v, input logic cv, input logic lsb);
        for (int k = 0; k < 8; k++) begin
            put_bit(lsb ? v[k] : v[7-k], cv);
        end
    endtask

    task automatic send_word(input logic [7:0] b0, input logic [7:0] b1,
                             input logic f0, input logic f1);
        lr_cur = ~lr_cur;
        case (fmt)
            2'd1: begin send_byte_ser(b0, f0, 1'b1); send_byte_ser(b1, f1, 1'b1); end
            2'd2: begin send_byte_ser(b0, f0, 1'b0); send_byte_ser(b1, f1, 1'b0); end
            default: begin send_byte_ser(b1, f1, 1'b0); send_byte_ser(b0, f0, 1'b0); end
        endcase
    endtask

    task automatic emit(input logic [7:0] raw, input logic cv, input logic expct,
                        input int idx, input logic st, input int tf);
        exp_t e;
        if (expct) begin
            e.b   = (idx < 12) ? raw : (raw ^ key[idx]);
            e.idx = 12'(idx);
            e.st  = st;
            e.c2  = cv;
            e.tf  = tf;
            e.td  = fmt_tag();
            expq.push_back(e);
        end
        if (!have_pend) begin
            pend_b = raw; pend_c = cv; have_pend = 1'b1;
        end else begin
            have_pend = 1'b0;
            send_word(pend_b, raw, pend_c, cv);
        end
    endtask

    task automatic set_cfg(input logic [1:0] f, input logic d, input logic ip);
        repeat (6) @(negedge clk);
        fmt = f; det_en = d; interp_en = ip;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [7:0] sync_b(input int i);
        return (i == 0 || i == 11) ? 8'h00 : 8'hFF;
    endfunction

    // kind 0: intact mark, 1: damaged mark; fake: mark copy at 1000..1011
    task automatic send_sector(input int sid, input int n, input int kind,
                               input int tf_start, input logic expct,
                               input logic fake, input logic det_off_at_100);
        logic [7:0] raw;
        int         tf;
        for (int i = 0; i < n; i++) begin
            if (det_off_at_100 && i == 100) set_cfg(fmt, 1'b0, interp_en);
            if (i < 12) raw = (kind == 1 && i == 5) ? 8'hFE : sync_b(i);
            else if (fake && i >= 1000 && i < 1012) raw = sync_b(i - 1000);
            else raw = 8'((i * 7) + (sid * 13) + 3);
            tf = (i == 0) ? tf_start : ((fake && i >= 1000 && i < 1012) ? 9 : 6);
            emit(raw, (i % 5 == 0) || (i % 7 == 3), expct, i, i == 0, tf);
        end
    endtask

    // Monitor: pop and compare every written byte
    always @(negedge clk) begin
        if (!rst && sec_wr) begin
            vectors++;
            if (expq.size() == 0) begin
                miscompares++;
                $display("FAIL R10 unexpected byte: actual idx=%0d byte=%02h expected=no output",
                         sec_idx, sec_byte);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (sec_idx !== e.idx || sec_start !== e.st) begin
                    miscompares++;
                    $display("FAIL %s idx/start: actual=%0d/%0b expected=%0d/%0b",
                             req_name(e.tf), sec_idx, sec_start, e.idx, e.st);
                end else if (sec_byte !== e.b) begin
                    miscompares++;
                    $display("FAIL %s%s byte at idx %0d: actual=%02h expected=%02h",
                             req_name(e.td), (e.idx >= 12) ? "+R11" : "", e.idx, sec_byte, e.b);
                end else if (sec_c2 !== e.c2) begin
                    miscompares++;
                    $display("FAIL R12 flag at idx %0d: actual=%0b expected=%0b",
                             e.idx, sec_c2, e.c2);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL R6 watchdog: actual=timeout expected=run complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst = 1'b1; bck = 1'b0; sd = 1'b0; lr = 1'b0; c2 = 1'b0;
        fmt = 2'd0; det_en = 1'b1; interp_en = 1'b1;
        repeat (4) @(negedge clk);
        // R1: outputs idle in reset
        vectors++;
        if (sec_wr !== 1'b0 || sec_start !== 1'b0 || sec_byte !== 8'h00 ||
            sec_idx !== 12'd0 || sec_c2 !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset: actual wr=%0b st=%0b b=%02h idx=%0d c2=%0b expected all zero",
                     sec_wr, sec_start, sec_byte, sec_idx, sec_c2);
        end
        rst = 1'b0;
        @(negedge clk);
        vectors++;
        if (sec_wr !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 after release: actual wr=%0b expected=0", sec_wr);
        end

        // junk before the first mark: nothing expected (R5)
        for (int i = 0; i < 6; i++) emit(8'hA5, 1'b0, 1'b0, 0, 1'b0, 5);
        // R2/R5: intact sector in format 0
        send_sector(1, NSEC, 0, 5, 1'b1, 1'b0, 1'b0);
        // R7: damaged mark, flywheel supplies the start
        send_sector(2, NSEC, 1, 7, 1'b1, 1'b0, 1'b0);
        // R3: format 1, cut short at 500 bytes
        set_cfg(2'd1, 1'b1, 1'b1);
        send_sector(3, 500, 0, 5, 1'b1, 1'b0, 1'b0);
        // R4/R8: format 2, early mark; R9: detection off with a fake mark inside
        set_cfg(2'd2, 1'b1, 1'b1);
        send_sector(4, NSEC, 0, 8, 1'b1, 1'b1, 1'b1);
        // R10: flywheel off, damaged mark at the boundary drops framing
        set_cfg(2'd3, 1'b1, 1'b0);
        send_sector(5, 30, 1, 10, 1'b0, 1'b0, 1'b0);
        // R10/R4: genuine mark restores framing, format 3 as format 0
        send_sector(6, 32, 0, 10, 1'b1, 1'b0, 1'b0);
        emit(8'h55, 1'b1, 1'b1, 32, 1'b0, 6);
        for (int i = 0; i < 11; i++) emit(8'h55, 1'b0, 1'b0, 0, 1'b0, 6);

        repeat (100) @(negedge clk);
        // R6: every expected byte emerged
        vectors++;
        if (expq.size() != 0) begin
            miscompares++;
            $display("FAIL R6 missing bytes: actual pending=%0d expected=0", expq.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule